// File: doc/BRIEF.md
# Serial Boot-Mode Configuration Loader

This block loads the boot-time configuration of a chip from an external serial source. It waits for power-good. It then produces a slow serial clock at 1/256 of the system clock and shifts in one mode bit on each rising edge of that clock, least significant bit first. When the last bit has arrived, it raises a done flag and presents the assembled mode vector. The vector then stays fixed until power-good is withdrawn.

Three fields are decoded from the vector:

- **Byte order.** The mode bit is merged with an external strap pin. Either one can select big-endian operation.
- **Output drive speed.** A two-bit code with a non-binary ordering is turned into a monotonic level from 0 (slowest) to 3 (fastest).
- **Mandatory strap bits.** Three bits must be programmed to 1. An error flag is raised when any of them is 0.

Every output other than the mode clock reads zero until the load is complete. Withdrawing power-good at any time aborts the load. The next load starts again from bit 0.

Top module: `bootcfg_loader`

## Requirements
- R1: While a load is running, `mode_clk_o` has a period of `DIV_RATIO` system clocks (default 256). It is low for the first half of each period and high for the second half. It is low whenever no load is running.
- R2: A load starts on the first system clock edge at which `pwr_good_i` is high. Stream bit k is sampled from `mode_din_i` at the edge where `mode_clk_o` rises, which is edge DIV_RATIO/2 + k*DIV_RATIO counted from that first edge. The first rise of `mode_clk_o` is therefore seen after edge 128.
- R3: The stream is `STREAM_BITS` long (default 256) and arrives least significant bit first. The bit sampled k-th appears at `mode_vec_o[k]`.
- R4: `done_o` rises one system clock after the final bit is sampled, and `mode_clk_o` is low from that clock on. `done_o` stays high while `pwr_good_i` stays high.
- R5: While `done_o` is low, `mode_vec_o`, `big_endian_o`, `drive_lvl_o` and `strap_err_o` are all zero.
- R6: After `done_o` rises, `mode_vec_o` and the fields decoded from it do not change, whatever `mode_din_i` does.
- R7: When `pwr_good_i` is sampled low, `done_o` and `mode_clk_o` are low after that edge and the bit position returns to 0. A later load fills the vector from bit 0.
- R8: Once done, `big_endian_o` is the OR of `endian_pin_i` and mode bit 8. The pin acts combinationally.
- R9: Once done, mode bits 14..13 set `drive_lvl_o` as follows: 2'b10 gives 3 (fastest, 100%), 2'b11 gives 2 (83%), 2'b00 gives 1 (67%) and 2'b01 gives 0 (slowest, 50%).
- R10: Once done, `strap_err_o` is high when any of mode bits 20, 33 or 37 is 0, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_good_i | input | 1 | Power-good; high starts a load, low clears the block synchronously |
| mode_din_i | input | 1 | Serial mode data |
| endian_pin_i | input | 1 | External big-endian strap |
| mode_clk_o | output | 1 | Serial mode clock (system clock / DIV_RATIO) |
| done_o | output | 1 | Mode vector complete |
| mode_vec_o | output | STREAM_BITS | Assembled mode vector, zero until done |
| big_endian_o | output | 1 | Effective big-endian selection |
| drive_lvl_o | output | 2 | Output drive speed level, 0 slowest to 3 fastest |
| strap_err_o | output | 1 | A mandatory mode bit was read as 0 |

## Verification
The hardest cases to reach from the ports are an abort part-way through a stream followed by a fresh load, and the freeze after completion. A stale bit position would only show up as a shifted vector many thousands of cycles later. The stimulus therefore withdraws power-good twenty bits into a patterned stream. It then runs several complete loads whose bit 0 and top bit differ from their neighbours, so any off-by-one in position becomes visible. Each load carries a different drive code and a different missing strap bit. After each completion, the data line is driven with pseudo-random bits while the endian pin is toggled.

// File: rtl/bootcfg_pkg.sv
package bootcfg_pkg;

    // Positions inside the mode vector that the decoder interprets.
    localparam int unsigned ENDIAN_BIT = 8;
    localparam int unsigned DRV_LO_BIT = 13;
    localparam int unsigned DRV_HI_BIT = 14;
    localparam int unsigned STRAP_A_BIT = 20;
    localparam int unsigned STRAP_B_BIT = 33;
    localparam int unsigned STRAP_C_BIT = 37;
    localparam int unsigned STRAP_COUNT = 3;
    localparam int unsigned MIN_STREAM = STRAP_C_BIT + 1;

    // Monotonic drive-speed level presented to the pad ring.
    typedef enum logic [1:0] {
        DRV_SLOWEST = 2'd0,
        DRV_SLOW    = 2'd1,
        DRV_FAST    = 2'd2,
        DRV_FASTEST = 2'd3
    } drive_lvl_e;

    // The field code is not ordered by speed; map it to a level.
    function automatic drive_lvl_e drive_from_code(input logic [1:0] code);
        drive_lvl_e lvl;
        unique case (code)
            2'b10:   lvl = DRV_FASTEST;
            2'b11:   lvl = DRV_FAST;
            2'b00:   lvl = DRV_SLOW;
            default: lvl = DRV_SLOWEST;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/bootcfg_clkdiv.sv
module bootcfg_clkdiv #(
    parameter int unsigned DIV_RATIO = 256
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic run_i,
    output logic mclk_o,
    output logic sample_o
);
    localparam int unsigned CW   = (DIV_RATIO > 2) ? $clog2(DIV_RATIO) : 1;
    localparam int unsigned HALF = DIV_RATIO / 2;
    localparam logic [CW-1:0] WRAP_AT   = CW'(DIV_RATIO - 1);
    localparam logic [CW-1:0] SAMPLE_AT = CW'(HALF - 1);
    localparam logic [CW-1:0] HIGH_FROM = CW'(HALF);

    typedef struct packed {
        logic [CW-1:0] phase;
        logic          mclk;
    } div_state_t;

    div_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i || !run_i) begin
            st_d.phase = '0;
            st_d.mclk  = 1'b0;
        end else begin
            st_d.phase = (st_q.phase == WRAP_AT) ? '0 : st_q.phase + 1'b1;
            st_d.mclk  = (st_d.phase >= HIGH_FROM);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    // Data is taken on the same system edge that drives the mode clock high.
    assign sample_o = run_i && !clr_i && (st_q.phase == SAMPLE_AT);
    assign mclk_o   = st_q.mclk;

endmodule

// File: rtl/bootcfg_shifter.sv
module bootcfg_shifter #(
    parameter int unsigned STREAM_BITS = 256
) (
    input  logic                   clk_i,
    input  logic                   clr_i,
    input  logic                   sample_i,
    input  logic                   din_i,
    output logic [STREAM_BITS-1:0] vec_o,
    output logic                   full_o
);
    localparam int unsigned CW = $clog2(STREAM_BITS + 1);
    localparam logic [CW-1:0] LAST_POS = CW'(STREAM_BITS - 1);

    typedef struct packed {
        logic [STREAM_BITS-1:0] vec;
        logic [CW-1:0]          pos;
        logic                   full;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.vec  = '0;
            st_d.pos  = '0;
            st_d.full = 1'b0;
        end else if (sample_i && !st_q.full) begin
            // Least significant bit first: each new bit enters at the top and
            // moves down, so the first bit ends at index 0.
            st_d.vec  = {din_i, st_q.vec[STREAM_BITS-1:1]};
            st_d.pos  = st_q.pos + 1'b1;
            st_d.full = (st_q.pos == LAST_POS);
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign vec_o  = st_q.vec;
    assign full_o = st_q.full;

endmodule

// File: rtl/bootcfg_decode.sv
module bootcfg_decode
    import bootcfg_pkg::*;
(
    input  logic                   valid_i,
    input  logic                   endian_bit_i,
    input  logic                   endian_pin_i,
    input  logic [1:0]             drive_code_i,
    input  logic [STRAP_COUNT-1:0] strap_i,
    output logic                   big_endian_o,
    output logic [1:0]             drive_lvl_o,
    output logic                   strap_err_o
);
    typedef struct packed {
        logic       big_endian;
        drive_lvl_e drive;
        logic       strap_err;
    } dec_out_t;

    dec_out_t out_d;
    logic     strap_ok;

    // Every mandatory bit must be set; reduce them through a generated chain.
    logic [STRAP_COUNT:0] ok_chain;
    assign ok_chain[0] = 1'b1;
    for (genvar g = 0; g < STRAP_COUNT; g++) begin : g_strap
        assign ok_chain[g+1] = ok_chain[g] & strap_i[g];
    end
    assign strap_ok = ok_chain[STRAP_COUNT];

    always_comb begin
        out_d = '0;
        if (valid_i) begin
            out_d.big_endian = endian_pin_i | endian_bit_i;
            out_d.drive      = drive_from_code(drive_code_i);
            out_d.strap_err  = !strap_ok;
        end
    end

    assign big_endian_o = out_d.big_endian;
    assign drive_lvl_o  = out_d.drive;
    assign strap_err_o  = out_d.strap_err;

endmodule

// File: rtl/bootcfg_loader.sv
module bootcfg_loader
    import bootcfg_pkg::*;
#(
    parameter int unsigned DIV_RATIO   = 256,
    parameter int unsigned STREAM_BITS = 256
) (
    input  logic                   clk_i,
    input  logic                   pwr_good_i,
    input  logic                   mode_din_i,
    input  logic                   endian_pin_i,
    output logic                   mode_clk_o,
    output logic                   done_o,
    output logic [STREAM_BITS-1:0] mode_vec_o,
    output logic                   big_endian_o,
    output logic [1:0]             drive_lvl_o,
    output logic                   strap_err_o
);
    typedef struct packed {
        logic                   done;
        logic [STREAM_BITS-1:0] cfg;
    } top_state_t;

    top_state_t st_d, st_q;

    logic                   clr;
    logic                   run;
    logic                   sample;
    logic                   full;
    logic [STREAM_BITS-1:0] shift_vec;

    // Power-good low is a synchronous clear for the whole block.
    assign clr = !pwr_good_i;
    assign run = pwr_good_i && !full;

    bootcfg_clkdiv #(
        .DIV_RATIO (DIV_RATIO)
    ) u_clkdiv (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .run_i    (run),
        .mclk_o   (mode_clk_o),
        .sample_o (sample)
    );

    bootcfg_shifter #(
        .STREAM_BITS (STREAM_BITS)
    ) u_shifter (
        .clk_i    (clk_i),
        .clr_i    (clr),
        .sample_i (sample),
        .din_i    (mode_din_i),
        .vec_o    (shift_vec),
        .full_o   (full)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.done = 1'b0;
            st_d.cfg  = '0;
        end else if (full && !st_q.done) begin
            // The last bit landed on the previous edge; publish it once.
            st_d.done = 1'b1;
            st_d.cfg  = shift_vec;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign done_o     = st_q.done;
    assign mode_vec_o = st_q.cfg;

    bootcfg_decode u_decode (
        .valid_i      (st_q.done),
        .endian_bit_i (st_q.cfg[ENDIAN_BIT]),
        .endian_pin_i (endian_pin_i),
        .drive_code_i (st_q.cfg[DRV_HI_BIT:DRV_LO_BIT]),
        .strap_i      ({st_q.cfg[STRAP_C_BIT], st_q.cfg[STRAP_B_BIT], st_q.cfg[STRAP_A_BIT]}),
        .big_endian_o (big_endian_o),
        .drive_lvl_o  (drive_lvl_o),
        .strap_err_o  (strap_err_o)
    );

    initial begin
        if (STREAM_BITS < MIN_STREAM) $error("STREAM_BITS too small for decoded fields");
        if (DIV_RATIO < 2) $error("DIV_RATIO must be at least 2");
    end

endmodule

// File: rtl/bootcfg_loader_chk.sv
module bootcfg_loader_chk #(
    parameter int unsigned DIV_RATIO   = 256,
    parameter int unsigned STREAM_BITS = 256
) (
    input logic                   clk_i,
    input logic                   pwr_good_i,
    input logic                   endian_pin_i,
    input logic                   mode_clk_o,
    input logic                   done_o,
    input logic [STREAM_BITS-1:0] mode_vec_o,
    input logic                   big_endian_o,
    input logic [1:0]             drive_lvl_o,
    input logic                   strap_err_o
);
    logic        prev_mclk_q;
    logic        armed_q;
    int unsigned gap_q;

    // Measure the distance between successive rising edges of the mode clock.
    always_ff @(posedge clk_i) begin
        if (!pwr_good_i) begin
            prev_mclk_q <= 1'b0;
            armed_q     <= 1'b0;
            gap_q       <= 0;
        end else begin
            prev_mclk_q <= mode_clk_o;
            if (mode_clk_o && !prev_mclk_q) begin
                armed_q <= 1'b1;
                gap_q   <= 0;
            end else begin
                gap_q <= gap_q + 1;
            end
        end
    end

    p_mclk_period_r1: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (mode_clk_o && !prev_mclk_q && armed_q) |-> (gap_q == DIV_RATIO - 1));

    p_mclk_quiet_done_r4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        done_o |-> !mode_clk_o);

    p_done_sticky_r4: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        done_o |=> done_o);

    p_outputs_zero_r5: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        !done_o |-> (mode_vec_o == '0 && !big_endian_o && drive_lvl_o == 2'd0 && !strap_err_o));

    p_vec_frozen_r6: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        ($past(done_o) && done_o) |-> $stable(mode_vec_o));

    p_abort_clears_r7: assert property (@(posedge clk_i)
        !pwr_good_i |=> (!done_o && !mode_clk_o));

    p_pin_forces_big_r8: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (done_o && endian_pin_i) |-> big_endian_o);

    p_fastest_code_r9: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (done_o && mode_vec_o[14:13] == 2'b10) |-> (drive_lvl_o == 2'd3));

    p_missing_strap_r10: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
        (done_o && !mode_vec_o[33]) |-> strap_err_o);

endmodule

bind bootcfg_loader bootcfg_loader_chk #(
    .DIV_RATIO   (DIV_RATIO),
    .STREAM_BITS (STREAM_BITS)
) u_chk (
    .clk_i        (clk_i),
    .pwr_good_i   (pwr_good_i),
    .endian_pin_i (endian_pin_i),
    .mode_clk_o   (mode_clk_o),
    .done_o       (done_o),
    .mode_vec_o   (mode_vec_o),
    .big_endian_o (big_endian_o),
    .drive_lvl_o  (drive_lvl_o),
    .strap_err_o  (strap_err_o)
);

// File: tb/tb_bootcfg_loader.sv
module tb_bootcfg_loader;
    localparam int DIV = 256;
    localparam int NB  = 64;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          pg = 1'b0;
    logic          din = 1'b0;
    logic          pin = 1'b0;
    logic          mclk, done, be, err;
    logic [NB-1:0] vec;
    logic [1:0]    drv;

    bootcfg_loader #(.DIV_RATIO(DIV), .STREAM_BITS(NB)) dut (
        .clk_i(clk), .pwr_good_i(pg), .mode_din_i(din), .endian_pin_i(pin),
        .mode_clk_o(mclk), .done_o(done), .mode_vec_o(vec),
        .big_endian_o(be), .drive_lvl_o(drv), .strap_err_o(err)
    );

    int vectors = 0;
    int fails   = 0;
    logic cmp_en = 1'b0;
    logic [NB-1:0] pat = '0;
    logic [15:0] lfsr = 16'hACE1;

    // Behavioural reference: counts edges and collects bits.
    int m_k = 0, m_cap = 0;
    logic m_done = 1'b0, m_mclk = 1'b0;
    logic [NB-1:0] m_shadow = '0, m_vec = '0;

    always @(posedge clk) begin
        if (!pg) begin
            m_k = 0; m_cap = 0; m_done = 1'b0; m_mclk = 1'b0;
            m_shadow = '0; m_vec = '0;
        end else if (!m_done) begin
            if (m_cap == NB) begin
                m_done = 1'b1; m_mclk = 1'b0; m_vec = m_shadow;
            end else begin
                m_k++;
                m_mclk = ((m_k % DIV) >= DIV / 2);
                if ((m_k % DIV) == DIV / 2) begin
                    m_shadow[m_cap] = din;
                    m_cap++;
                end
            end
        end
    end

    function automatic logic [1:0] exp_drive(input logic [1:0] code);
        case (code)
            2'b10:   return 2'd3;
            2'b11:   return 2'd2;
            2'b00:   return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the reference.
    always @(negedge clk) begin
        if (cmp_en) begin
            logic          e_be, e_err;
            logic [1:0]    e_drv;
            e_be  = m_done & (pin | m_vec[8]);
            e_drv = m_done ? exp_drive(m_vec[14:13]) : 2'd0;
            e_err = m_done & ~(m_vec[20] & m_vec[33] & m_vec[37]);
            chk(mclk === m_mclk, "R1 mode clock", 64'(mclk), 64'(m_mclk));
            chk(done === m_done, "R4 done flag", 64'(done), 64'(m_done));
            chk(vec === m_vec, m_done ? "R3 mode vector" : "R5 vector before done", 64'(vec), 64'(m_vec));
            chk(be === e_be, "R8 endian", 64'(be), 64'(e_be));
            chk(drv === e_drv, "R9 drive level", 64'(drv), 64'(e_drv));
            chk(err === e_err, "R10 strap error", 64'(err), 64'(e_err));
        end
    end

    // Serial source: the pattern while loading, pseudo-random noise otherwise.
    always begin
        @(negedge clk);
        #2;
        if (pg && !m_done && m_cap < NB) begin
            din = pat[m_cap];
        end else begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            din  = lfsr[0];
        end
    end

    function automatic logic [NB-1:0] mk(input logic [NB-1:0] base, input logic b8,
                                         input logic [1:0] dc, input logic [2:0] s);
        logic [NB-1:0] p;
        p = base;
        p[8] = b8;
        p[14:13] = dc;
        p[20] = s[0];
        p[33] = s[1];
        p[37] = s[2];
        return p;
    endfunction

    task automatic run_load(input logic [NB-1:0] p, input logic [1:0] e_drv, input logic e_err);
        int n;
        logic [NB-1:0] snap;
        @(negedge clk); #2;
        pat = p; pin = 1'b0; pg = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!done && n < NB * DIV + 1000);
        chk(n == NB * DIV - DIV / 2 + 1, "R4 done timing", 64'(n), 64'(NB * DIV - DIV / 2 + 1));
        chk(mclk == 1'b0, "R4 mode clock low at done", 64'(mclk), 64'd0);
        chk(vec == p, "R3 R7 vector from bit 0", 64'(vec), 64'(p));
        chk(vec[0] == p[0] && vec[NB-1] == p[NB-1], "R3 end bits", 64'({vec[NB-1], vec[0]}), 64'({p[NB-1], p[0]}));
        chk(drv == e_drv, "R9 drive code", 64'(drv), 64'(e_drv));
        chk(err == e_err, "R10 strap flag", 64'(err), 64'(e_err));
        chk(be == p[8], "R8 endian pin low", 64'(be), 64'(p[8]));
        #2 pin = 1'b1;
        @(negedge clk);
        chk(be == 1'b1, "R8 endian pin high", 64'(be), 64'd1);
        snap = vec;
        repeat (300) @(negedge clk);
        chk(vec == snap && done, "R6 frozen after done", 64'(vec), 64'(snap));
        #2 pg = 1'b0; pin = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int n;
        repeat (5) @(negedge clk);
        chk(done == 1'b0, "R5 reset done", 64'(done), 64'd0);
        chk(vec == '0 && !be && drv == 0 && !err, "R5 reset outputs", 64'(vec), 64'd0);
        chk(mclk == 1'b0, "R1 idle mode clock", 64'(mclk), 64'd0);
        cmp_en = 1'b1;

        // Start a load, check the first clock rise, then abort midway.
        #2 pat = 64'hDEAD_BEEF_0123_4567; pg = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!mclk && n < 1000);
        chk(n == DIV / 2, "R2 first mode clock rise", 64'(n), 64'(DIV / 2));
        repeat (20 * DIV) @(negedge clk);
        #2 pg = 1'b0;
        @(negedge clk);
        chk(!done && !mclk, "R7 abort clears", 64'({done, mclk}), 64'd0);
        repeat (3) @(negedge clk);

        run_load(mk(64'h8000_0000_0000_0001, 1'b0, 2'b10, 3'b111), 2'd3, 1'b0);
        run_load(mk(64'h5A5A_0F0F_3C3C_9696, 1'b1, 2'b11, 3'b101), 2'd2, 1'b1);
        run_load(mk(64'h7FFF_FFFF_FFFF_FFFE, 1'b0, 2'b00, 3'b011), 2'd1, 1'b1);
        run_load(mk(64'hC001_8002_4004_2008, 1'b1, 2'b01, 3'b110), 2'd0, 1'b1);

        cmp_en = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog expired act=%0d exp=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule